// File: doc/BRIEF.md
# External Pin Interrupt Unit

This block turns up to seven external pins into interrupt requests for a downstream interrupt controller. Each pin is sampled through a short synchronizer. A per-pin trigger selector then picks one of two behaviours. In level mode the request follows the pin while it is held low. In the edge modes (rising, falling or either direction), each detected event sets a sticky flag, and the request follows that flag. Software clears a flag by writing a one to its bit. A per-pin enable gates each request. A direction bit can instead turn the pin into a driven output.

Software reaches the block through a small register bus. The bus has a write strobe, a three-bit register index, write data as wide as the trigger register, and combinational read data. Pin position 0 is reserved. Every register bit at that position reads as zero, and that position never raises a request.

Top module: `xirq_port`

## Requirements
- R1: After reset every register reads zero, `irq_req` is all zeros and `pad_oe` is all zeros. This means all pins are in level mode, are inputs and are disabled.
- R2: Position 0 is reserved. Writes to bit 0 of the direction, enable, flag and output-data registers have no effect, and those bits read 0. Bits [1:0] of the trigger register also read 0. `irq_req[0]` and `pad_oe[0]` stay 0.
- R3: The trigger register (index 0) gives pin p a 2-bit field at bits [2p+1:2p]. The encoding is 00 = level, 01 = rising edge, 10 = falling edge, 11 = both edges. The register reads back what was written, except for bits [1:0].
- R4: In level mode, `irq_req[p]` is 1 exactly while the synchronized pin is low and its enable bit is set. No flag is latched in this mode.
- R5: In an edge mode, a qualifying transition on the synchronized pin sets flag bit p (flag register, index 3). A transition of the other direction does not set it in rising-only or falling-only mode. Both directions set it in mode 11.
- R6: Writing the flag register clears each flag whose written bit is 1. Flags whose written bit is 0 keep their value.
- R7: If an edge event and a clearing write for the same pin fall in the same cycle, the flag remains set.
- R8: In an edge mode, `irq_req[p]` equals flag p AND enable p (enable register, index 2). A disabled pin still latches its flag.
- R9: Direction bit p (index 1) set to 1 drives `pad_oe[p]`. `pad_out[p]` carries bit p of the output-data register (index 4). A direction bit of 0 leaves the pin as an input.
- R10: A change on `pad_in` reaches the level-mode request after two rising clock edges, and not after one.
- R11: Reads of register indices 5 to 7 return zero. The 8-bit registers read zero-extended in `bus_rdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register index |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr` (combinational) |
| pad_in | input | 8 | Raw external pin levels |
| pad_out | output | 8 | Output value for pins configured as outputs |
| pad_oe | output | 8 | Output enable per pin |
| irq_req | output | 8 | Interrupt request per pin, bit 0 always 0 |

## Verification
The bench builds the block with its defaults: eight positions and a two-stage synchronizer. With these values the trigger register fills the whole 16-bit bus. This puts the top field at bits [15:14], which the both-edges test exercises on pin 7, and it leaves position 0 as the reserved slot whose masking is checked. The two-stage depth fixes the request latency at two edges. That latency lets the bench time a clearing write so that it lands in exactly the cycle of a new edge event.

// File: rtl/xirq_pkg.sv
package xirq_pkg;

    typedef enum logic [1:0] {
        TRIG_LEVEL = 2'b00,
        TRIG_RISE  = 2'b01,
        TRIG_FALL  = 2'b10,
        TRIG_BOTH  = 2'b11
    } trig_e;

    localparam int ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        RA_TRIG  = 3'd0,
        RA_DIR   = 3'd1,
        RA_EN    = 3'd2,
        RA_FLAG  = 3'd3,
        RA_DOUT  = 3'd4
    } reg_addr_e;

    // One synchronized sample plus the sample before it
    typedef struct packed {
        logic cur;
        logic prev;
    } pin_hist_t;

    function automatic logic edge_hit(trig_e mode, pin_hist_t h);
        case (mode)
            TRIG_RISE: return h.cur & ~h.prev;
            TRIG_FALL: return ~h.cur & h.prev;
            TRIG_BOTH: return h.cur ^ h.prev;
            default:   return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/xirq_sync.sv
module xirq_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/xirq_pin_detect.sv
module xirq_pin_detect
    import xirq_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  pin_raw,
    input  trig_e mode,
    input  logic  en,
    input  logic  clr,
    output logic  flag,
    output logic  req
);
    pin_hist_t hist;
    logic      hit;

    xirq_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (pin_raw),
        .q   (hist.cur)
    );

    always_ff @(posedge clk) begin
        if (rst) hist.prev <= 1'b0;
        else     hist.prev <= hist.cur;
    end

    assign hit = edge_hit(mode, hist);

    // A new event outranks a clear issued in the same cycle
    always_ff @(posedge clk) begin
        if (rst)      flag <= 1'b0;
        else if (hit) flag <= 1'b1;
        else if (clr) flag <= 1'b0;
    end

    always_comb begin
        if (mode == TRIG_LEVEL) req = en & ~hist.cur;
        else                    req = en & flag;
    end

    // R4: level mode never latches a flag
    a_r4_level_no_flag: assert property (@(posedge clk) disable iff (rst)
        (mode == TRIG_LEVEL && !flag) |=> !flag);

    // R7: an edge event always leaves the flag set
    a_r7_edge_wins: assert property (@(posedge clk) disable iff (rst)
        hit |=> flag);

    // R6: a clear with no competing event empties the flag
    a_r6_clear: assert property (@(posedge clk) disable iff (rst)
        (clr && !hit) |=> !flag);

    // R8: no request without enable
    a_r8_req_gated: assert property (@(posedge clk) disable iff (rst)
        !en |-> !req);
endmodule

// File: rtl/xirq_regs.sv
module xirq_regs
    import xirq_pkg::*;
#(
    parameter int NUM_PINS = 8
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  bus_wr,
    input  logic [ADDR_W-1:0]     bus_addr,
    input  logic [2*NUM_PINS-1:0] bus_wdata,
    output logic [2*NUM_PINS-1:0] bus_rdata,
    input  logic [NUM_PINS-1:0]   flags,
    output logic [2*NUM_PINS-1:0] trig_q,
    output logic [NUM_PINS-1:0]   dir_q,
    output logic [NUM_PINS-1:0]   en_q,
    output logic [NUM_PINS-1:0]   dout_q,
    output logic [NUM_PINS-1:0]   clr
);
    localparam int DW = 2 * NUM_PINS;
    localparam logic [NUM_PINS-1:0] KEEP      = {{(NUM_PINS-1){1'b1}}, 1'b0};
    localparam logic [DW-1:0]       TRIG_KEEP = {{(DW-2){1'b1}}, 2'b00};

    logic [NUM_PINS-1:0] wbyte;
    assign wbyte = bus_wdata[NUM_PINS-1:0] & KEEP;

    always_ff @(posedge clk) begin
        if (rst) begin
            trig_q <= '0;
            dir_q  <= '0;
            en_q   <= '0;
            dout_q <= '0;
        end else if (bus_wr) begin
            case (bus_addr)
                RA_TRIG: trig_q <= bus_wdata & TRIG_KEEP;
                RA_DIR:  dir_q  <= wbyte;
                RA_EN:   en_q   <= wbyte;
                RA_DOUT: dout_q <= wbyte;
                default: ;
            endcase
        end
    end

    assign clr = (bus_wr && bus_addr == RA_FLAG) ? wbyte : '0;

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            RA_TRIG: bus_rdata = trig_q;
            RA_DIR:  bus_rdata[NUM_PINS-1:0] = dir_q;
            RA_EN:   bus_rdata[NUM_PINS-1:0] = en_q;
            RA_FLAG: bus_rdata[NUM_PINS-1:0] = flags & KEEP;
            RA_DOUT: bus_rdata[NUM_PINS-1:0] = dout_q;
            default: bus_rdata = '0;
        endcase
    end

    // R3: a trigger write is held on the following cycle
    a_r3_trig_write: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == RA_TRIG) |=> (trig_q == ($past(bus_wdata) & TRIG_KEEP)));
endmodule

// File: rtl/xirq_port.sv
module xirq_port
    import xirq_pkg::*;
#(
    parameter int NUM_PINS    = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  bus_wr,
    input  logic [ADDR_W-1:0]     bus_addr,
    input  logic [2*NUM_PINS-1:0] bus_wdata,
    output logic [2*NUM_PINS-1:0] bus_rdata,
    input  logic [NUM_PINS-1:0]   pad_in,
    output logic [NUM_PINS-1:0]   pad_out,
    output logic [NUM_PINS-1:0]   pad_oe,
    output logic [NUM_PINS-1:0]   irq_req
);
    localparam logic [NUM_PINS-1:0] KEEP = {{(NUM_PINS-1){1'b1}}, 1'b0};

    logic [2*NUM_PINS-1:0] trig_q;
    logic [NUM_PINS-1:0]   dir_q, en_q, dout_q, clr, flags;

    xirq_regs #(.NUM_PINS(NUM_PINS)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .flags     (flags),
        .trig_q    (trig_q),
        .dir_q     (dir_q),
        .en_q      (en_q),
        .dout_q    (dout_q),
        .clr       (clr)
    );

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
        xirq_pin_detect #(.SYNC_STAGES(SYNC_STAGES)) u_det (
            .clk     (clk),
            .rst     (rst),
            .pin_raw (pad_in[p]),
            .mode    (trig_e'(trig_q[2*p +: 2])),
            .en      (en_q[p]),
            .clr     (clr[p]),
            .flag    (flags[p]),
            .req     (irq_req[p])
        );
    end

    assign pad_oe  = dir_q;
    assign pad_out = dout_q;

    // R2: the reserved position stays silent
    a_r2_reserved: assert property (@(posedge clk) disable iff (rst)
        !irq_req[0] && !pad_oe[0] && !bus_rdata[0]);

    // R1: the first cycle after reset is quiet
    a_r1_reset_quiet: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (irq_req == '0 && pad_oe == '0));

    // R9: a direction write shows up on the output enables
    a_r9_dir_drive: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == RA_DIR) |=> (pad_oe == ($past(bus_wdata[NUM_PINS-1:0]) & KEEP)));
endmodule

// File: tb/xirq_port_test.sv
module xirq_port_test;
    import xirq_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic [7:0]  pad_in = 8'hFF;
    logic [7:0]  pad_out, pad_oe, irq_req;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    xirq_port uut (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
        .pad_out(pad_out), .pad_oe(pad_oe), .irq_req(irq_req)
    );

    always #5 clk = ~clk;

    task automatic check(string req, logic [15:0] act, logic [15:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(logic [2:0] a, logic [15:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(logic [2:0] a, output logic [15:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    task automatic drive_pin(int p, logic v);
        @(negedge clk);
        pad_in[p] = v;
        settle();
    endtask

    task automatic cfg(logic [15:0] trig, logic [7:0] en);
        wr(RA_TRIG, trig);
        wr(RA_EN, {8'h00, en});
        wr(RA_FLAG, 16'h00FF);
    endtask

    task automatic t_reset();
        logic [15:0] d;
        for (int a = 0; a < 5; a++) begin
            rd(3'(a), d);
            check("R1 reg after reset", d, 16'h0);
        end
        check("R1 irq_req after reset", {8'h0, irq_req}, 16'h0);
        check("R1 pad_oe after reset", {8'h0, pad_oe}, 16'h0);
    endtask

    task automatic t_regmap();
        logic [15:0] d;
        wr(RA_TRIG, 16'hFFFF);
        rd(RA_TRIG, d);
        check("R2 R3 trig bits[1:0] reserved", d, 16'hFFFC);
        wr(RA_TRIG, 16'hE010);
        rd(RA_TRIG, d);
        check("R3 trig readback", d, 16'hE010);
        wr(RA_DOUT, 16'hFFFF);
        rd(RA_DOUT, d);
        check("R2 R11 dout readback masked", d, 16'h00FE);
        for (int a = 5; a < 8; a++) begin
            rd(3'(a), d);
            check("R11 unmapped index reads zero", d, 16'h0);
        end
        wr(RA_TRIG, 16'h0);
        wr(RA_DOUT, 16'h0);
    endtask

    task automatic t_level();
        logic [15:0] d;
        cfg(16'h0000, 8'h09);                 // pin 3 level, bit 0 enable ignored
        check("R4 high pin no request", {8'h0, irq_req}, 16'h0);
        drive_pin(3, 1'b0);
        check("R4 low pin requests", {8'h0, irq_req}, 16'h0008);
        rd(RA_FLAG, d);
        check("R4 level latches no flag", d, 16'h0);
        drive_pin(0, 1'b0);
        check("R2 pin 0 never requests", {8'h0, irq_req}, 16'h0008);
        drive_pin(3, 1'b1);
        drive_pin(0, 1'b1);
        check("R4 request drops with pin", {8'h0, irq_req}, 16'h0);
    endtask

    task automatic t_sync_latency();
        cfg(16'h0000, 8'h20);                 // pin 5 level
        @(negedge clk);
        pad_in[5] = 1'b0;
        @(negedge clk);
        check("R10 not after one edge", {15'h0, irq_req[5]}, 16'h0);
        @(negedge clk);
        check("R10 after two edges", {15'h0, irq_req[5]}, 16'h1);
        drive_pin(5, 1'b1);
    endtask

    task automatic t_rise_w1c();
        logic [15:0] d;
        cfg(16'h0010, 8'h04);                 // pin 2 rising
        drive_pin(2, 1'b0);
        rd(RA_FLAG, d);
        check("R5 falling ignored in rise mode", d, 16'h0);
        drive_pin(2, 1'b1);
        rd(RA_FLAG, d);
        check("R5 rising sets flag", d, 16'h0004);
        check("R8 flag drives request", {8'h0, irq_req}, 16'h0004);
        wr(RA_FLAG, 16'h00FB);
        rd(RA_FLAG, d);
        check("R6 zero bit keeps flag", d, 16'h0004);
        wr(RA_FLAG, 16'h0004);
        rd(RA_FLAG, d);
        check("R6 one bit clears flag", d, 16'h0);
        check("R8 request follows clear", {8'h0, irq_req}, 16'h0);
    endtask

    task automatic t_fall();
        logic [15:0] d;
        cfg(16'h2000, 8'h40);                 // pin 6 falling
        drive_pin(6, 1'b0);
        rd(RA_FLAG, d);
        check("R5 falling sets flag", d, 16'h0040);
        wr(RA_FLAG, 16'h0040);
        drive_pin(6, 1'b1);
        rd(RA_FLAG, d);
        check("R5 rising ignored in fall mode", d, 16'h0);
    endtask

    task automatic t_both_collide();
        logic [15:0] d;
        cfg(16'hC000, 8'h80);                 // pin 7 both edges
        drive_pin(7, 1'b0);
        rd(RA_FLAG, d);
        check("R5 both mode falling", d, 16'h0080);
        wr(RA_FLAG, 16'h0080);
        drive_pin(7, 1'b1);
        rd(RA_FLAG, d);
        check("R5 both mode rising", d, 16'h0080);
        // flag is set; new edge and clear meet in one cycle
        @(negedge clk);
        pad_in[7] = 1'b0;
        @(negedge clk);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = RA_FLAG; bus_wdata = 16'h0080;
        @(negedge clk);
        bus_wr = 1'b0;
        rd(RA_FLAG, d);
        check("R7 event beats same-cycle clear", d, 16'h0080);
        wr(RA_FLAG, 16'h0080);
        drive_pin(7, 1'b1);
        wr(RA_FLAG, 16'h0080);
    endtask

    task automatic t_enable_gate();
        logic [15:0] d;
        cfg(16'h0004, 8'h00);                 // pin 1 rising, disabled
        drive_pin(1, 1'b0);
        drive_pin(1, 1'b1);
        rd(RA_FLAG, d);
        check("R8 disabled pin latches flag", d, 16'h0002);
        check("R8 disabled pin no request", {8'h0, irq_req}, 16'h0);
        wr(RA_EN, 16'h0002);
        @(negedge clk);
        check("R8 enable exposes flag", {8'h0, irq_req}, 16'h0002);
        cfg(16'h0000, 8'h00);
    endtask

    task automatic t_direction();
        wr(RA_DIR, 16'h0081);
        wr(RA_DOUT, 16'h00A5);
        @(negedge clk);
        check("R9 R2 output enables", {8'h0, pad_oe}, 16'h0080);
        check("R9 R2 output data", {8'h0, pad_out}, 16'h00A4);
        wr(RA_DIR, 16'h0);
        @(negedge clk);
        check("R9 cleared bit makes input", {8'h0, pad_oe}, 16'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_regmap();
        t_level();
        t_sync_latency();
        t_rise_w1c();
        t_fall();
        t_both_collide();
        t_enable_gate();
        t_direction();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule